// File: doc/BRIEF.md
# Dual Servo Pulse Generator with Period-Boundary Reload

This block drives two servo control lines from one shared period counter. Each channel receives a signed position command, from full left to full right. The block turns that command into a pulse width that lies between a configurable shortest and longest pulse. Both outputs are edge-aligned and high-true. They rise together when the counter returns to zero, and each falls when the count reaches that channel's compare value.

A position write never disturbs a pulse that is already running. The write lands in a shadow register. The shadow register is copied into the live compare register only when the counter wraps. Each wrap also raises a one-cycle frame-start strobe, which a downstream capture sequencer can use as its trigger. Each wrap also advances a frame tick count that stops at its maximum value instead of rolling over.

The period, the pulse limits and the tick count width are all given in clock ticks or bits as parameters. With a 1 MHz tick, the defaults give a 20 ms frame and pulses between 0.95 ms and 1.60 ms.

Top module: `servo_pwm_pair`

## Requirements
- R1: While reset is high and in the first period after its release, the frame-start strobe is 0 and the tick count is 0. Both channels use the neutral compare value (position 0) in their shadow and live registers, so the first period carries neutral-width pulses.
- R2: The frame-start strobe is high for exactly one cycle in every PERIOD_TICKS cycles. The first strobe comes PERIOD_TICKS cycles after reset is released. The strobe falls in the cycle where the counter has just returned to zero.
- R3: A position is a 16-bit two's-complement fraction: -32768 is full left, 0 is neutral and 32767 is full right. It maps to the compare value MIN_TICKS + floor((pos + 32768) * (MAX_TICKS - MIN_TICKS) / 65536).
- R4: In each period a channel output is high from the counter-zero cycle for exactly as many cycles as its live compare value, and low for the rest of the period.
- R5: A write during a period does not change that period's pulses. The new value takes effect from the next period.
- R6: A write presented in the last cycle of a period misses the boundary that immediately follows. It takes effect one period later.
- R7: When a channel is written more than once within one period, only the last write takes effect.
- R8: A write to one channel never changes the pulse width of the other channel.
- R9: The tick count rises by exactly one in the same cycle that the frame-start strobe is high. It holds at all ones once it gets there, and it changes at no other time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pos0 | input | 16 | Channel 0 position command, signed fraction |
| pos0_wr | input | 1 | Write strobe for pos0 |
| pos1 | input | 16 | Channel 1 position command, signed fraction |
| pos1_wr | input | 1 | Write strobe for pos1 |
| pwm0 | output | 1 | Channel 0 pulse output, high-true |
| pwm1 | output | 1 | Channel 1 pulse output, high-true |
| frame_start | output | 1 | One-cycle strobe at each period boundary |
| tick_count | output | TICK_W | Saturating count of period boundaries |

## Verification
A corrupted shadow or live compare register shows up as a wrong pulse width. It appears in the very next period, at most PERIOD_TICKS cycles after the fault, and the per-cycle comparison of both outputs against a bench model catches it on the first wrong cycle. A fault in the counter moves the frame-start strobe off its PERIOD_TICKS spacing within one period. A fault in the tick logic shows at the next strobe, as a missed step or a wrap past all ones. A fault in the reload timing (loading early, late or from the wrong source) shows as a width change in the period of the write itself, or one period too late.

// File: rtl/servo_pwm_pkg.sv
package servo_pwm_pkg;

    // Width of the signed position command (Q1.15)
    localparam int unsigned POS_W = 16;

    // One channel's write request as seen by the datapath
    typedef struct packed {
        logic                    wr;
        logic signed [POS_W-1:0] pos;
    } pos_cmd_t;

    // Map a signed fraction onto [lo, lo+span):
    // lo + floor((pos + 2^15) * span / 2^16)
    function automatic int unsigned pos_to_cmp(
        input logic signed [POS_W-1:0] pos,
        input int unsigned             lo,
        input int unsigned             span
    );
        logic [POS_W-1:0] offs;
        logic [47:0]      prod;
        offs = {~pos[POS_W-1], pos[POS_W-2:0]};
        prod = 48'(offs) * 48'(span);
        return lo + 32'(prod >> 16);
    endfunction

endpackage

// File: rtl/spwm_period_ctr.sv
module spwm_period_ctr #(
    parameter int unsigned PERIOD_TICKS = 20000,
    parameter int unsigned CW           = $clog2(PERIOD_TICKS + 1)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [CW-1:0] cnt_o,
    output logic          wrap_o
);

    localparam logic [CW-1:0] LAST = CW'(PERIOD_TICKS - 1);

    // Last cycle of the period: the next edge returns the count to zero
    assign wrap_o = (cnt_o == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_o <= '0;
        end else if (wrap_o) begin
            cnt_o <= '0;
        end else begin
            cnt_o <= cnt_o + CW'(1);
        end
    end

endmodule

// File: rtl/spwm_channel.sv
module spwm_channel
    import servo_pwm_pkg::*;
#(
    parameter int unsigned CW        = 16,
    parameter int unsigned MIN_TICKS = 950,
    parameter int unsigned MAX_TICKS = 1600
) (
    input  logic          clk,
    input  logic          rst,
    input  pos_cmd_t      cmd_i,
    input  logic          load_i,
    input  logic [CW-1:0] cnt_i,
    output logic [CW-1:0] act_o,
    output logic          pwm_o
);

    localparam int unsigned   SPAN    = MAX_TICKS - MIN_TICKS;
    localparam logic [CW-1:0] NEUTRAL = CW'(pos_to_cmp(16'sd0, MIN_TICKS, SPAN));

    logic [CW-1:0] shadow_q;
    logic [CW-1:0] wr_cmp;

    always_comb begin
        wr_cmp = CW'(pos_to_cmp(cmd_i.pos, MIN_TICKS, SPAN));
    end

    // The live register copies the shadow value held before this edge,
    // so a write on the boundary cycle waits one more period
    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= NEUTRAL;
            act_o    <= NEUTRAL;
        end else begin
            if (cmd_i.wr) begin
                shadow_q <= wr_cmp;
            end
            if (load_i) begin
                act_o <= shadow_q;
            end
        end
    end

    // Edge-aligned, high-true
    assign pwm_o = (cnt_i < act_o);

endmodule

// File: rtl/spwm_frame_tick.sv
module spwm_frame_tick #(
    parameter int unsigned TICK_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wrap_i,
    output logic              start_o,
    output logic [TICK_W-1:0] tick_o
);

    localparam logic [TICK_W-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            start_o <= 1'b0;
            tick_o  <= '0;
        end else begin
            start_o <= wrap_i;
            if (wrap_i && (tick_o != TOP)) begin
                tick_o <= tick_o + TICK_W'(1);
            end
        end
    end

endmodule

// File: rtl/servo_pwm_pair.sv
module servo_pwm_pair
    import servo_pwm_pkg::*;
#(
    parameter int unsigned PERIOD_TICKS = 20000,
    parameter int unsigned MIN_TICKS    = 950,
    parameter int unsigned MAX_TICKS    = 1600,
    parameter int unsigned TICK_W       = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic signed [POS_W-1:0] pos0,
    input  logic                    pos0_wr,
    input  logic signed [POS_W-1:0] pos1,
    input  logic                    pos1_wr,
    output logic                    pwm0,
    output logic                    pwm1,
    output logic                    frame_start,
    output logic [TICK_W-1:0]       tick_count
);

    localparam int unsigned NCH = 2;
    localparam int unsigned CW  = $clog2(PERIOD_TICKS + 1);

    logic [CW-1:0] cnt_q;
    logic          wrap;
    pos_cmd_t      cmd     [NCH];
    logic [CW-1:0] act_cmp [NCH];
    logic          pwm_v   [NCH];

    assign cmd[0] = '{wr: pos0_wr, pos: pos0};
    assign cmd[1] = '{wr: pos1_wr, pos: pos1};

    spwm_period_ctr #(
        .PERIOD_TICKS(PERIOD_TICKS),
        .CW          (CW)
    ) u_ctr (
        .clk   (clk),
        .rst   (rst),
        .cnt_o (cnt_q),
        .wrap_o(wrap)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        spwm_channel #(
            .CW       (CW),
            .MIN_TICKS(MIN_TICKS),
            .MAX_TICKS(MAX_TICKS)
        ) u_ch (
            .clk   (clk),
            .rst   (rst),
            .cmd_i (cmd[ch]),
            .load_i(wrap),
            .cnt_i (cnt_q),
            .act_o (act_cmp[ch]),
            .pwm_o (pwm_v[ch])
        );
    end

    spwm_frame_tick #(
        .TICK_W(TICK_W)
    ) u_tick (
        .clk    (clk),
        .rst    (rst),
        .wrap_i (wrap),
        .start_o(frame_start),
        .tick_o (tick_count)
    );

    assign pwm0 = pwm_v[0];
    assign pwm1 = pwm_v[1];

endmodule

// File: rtl/spwm_checker.sv
module spwm_checker #(
    parameter int unsigned CW     = 16,
    parameter int unsigned TICK_W = 32,
    parameter int unsigned MIN_T  = 950,
    parameter int unsigned MAX_T  = 1600
) (
    input logic              clk,
    input logic              rst,
    input logic [CW-1:0]     cnt,
    input logic [CW-1:0]     act0,
    input logic [CW-1:0]     act1,
    input logic              pwm0,
    input logic              pwm1,
    input logic              frame_start,
    input logic [TICK_W-1:0] tick
);

    assert_start_single_R2: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> !frame_start);

    assert_start_at_zero_R2: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> (cnt == '0));

    assert_rise0_at_zero_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(pwm0) |-> (cnt == '0));

    assert_rise1_at_zero_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(pwm1) |-> (cnt == '0));

    assert_load0_boundary_R5: assert property (@(posedge clk) disable iff (rst)
        (act0 != $past(act0)) |-> (cnt == '0));

    assert_load1_boundary_R5: assert property (@(posedge clk) disable iff (rst)
        (act1 != $past(act1)) |-> (cnt == '0));

    assert_range0_R3: assert property (@(posedge clk) disable iff (rst)
        (act0 >= CW'(MIN_T)) && (act0 <= CW'(MAX_T)));

    assert_range1_R3: assert property (@(posedge clk) disable iff (rst)
        (act1 >= CW'(MIN_T)) && (act1 <= CW'(MAX_T)));

    assert_tick_step_R9: assert property (@(posedge clk) disable iff (rst)
        (tick != $past(tick)) |-> (frame_start && (tick == $past(tick) + TICK_W'(1))));

    assert_tick_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (frame_start && ($past(tick) == '1)) |-> (tick == '1));

endmodule

bind servo_pwm_pair spwm_checker #(
    .CW    (CW),
    .TICK_W(TICK_W),
    .MIN_T (MIN_TICKS),
    .MAX_T (MAX_TICKS)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cnt        (cnt_q),
    .act0       (act_cmp[0]),
    .act1       (act_cmp[1]),
    .pwm0       (pwm0),
    .pwm1       (pwm1),
    .frame_start(frame_start),
    .tick       (tick_count)
);

// File: tb/sim_servo_pwm_pair.sv
`timescale 1ns/1ps
module sim_servo_pwm_pair;

    localparam int P    = 40;
    localparam int MINT = 8;
    localparam int MAXT = 20;
    localparam int TW   = 3;
    localparam int TMAX = (1 << TW) - 1;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic signed [15:0] pos0 = '0;
    logic signed [15:0] pos1 = '0;
    logic               pos0_wr = 1'b0;
    logic               pos1_wr = 1'b0;
    logic               pwm0, pwm1, frame_start;
    logic [TW-1:0]      tick_count;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // bench reference state
    int    ph = 0;
    int    sh0, sh1, ac0, ac1;
    int    fs_exp = 0;
    int    tick_exp = 0;
    string tg = "R1";

    always #2.5 clk = ~clk;

    servo_pwm_pair #(
        .PERIOD_TICKS(P),
        .MIN_TICKS   (MINT),
        .MAX_TICKS   (MAXT),
        .TICK_W      (TW)
    ) u0 (
        .clk        (clk),
        .rst        (rst),
        .pos0       (pos0),
        .pos0_wr    (pos0_wr),
        .pos1       (pos1),
        .pos1_wr    (pos1_wr),
        .pwm0       (pwm0),
        .pwm1       (pwm1),
        .frame_start(frame_start),
        .tick_count (tick_count)
    );

    function automatic int map_pos(input int p);
        return MINT + ((p + 32768) * (MAXT - MINT)) / 65536;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d (phase %0d)", tag, act, exp, ph);
        end
    endtask

    // check this cycle, drive inputs, advance the model by one edge
    task automatic step(input bit w0, input int p0, input bit w1, input int p1);
        chk(tg, int'(pwm0), int'(ph < ac0));
        chk(tg, int'(pwm1), int'(ph < ac1));
        chk("R2", int'(frame_start), fs_exp);
        chk("R9", int'(tick_count), tick_exp);
        pos0 = 16'(p0); pos0_wr = w0;
        pos1 = 16'(p1); pos1_wr = w1;
        if (ph == P - 1) begin
            ac0 = sh0;
            ac1 = sh1;
        end
        if (w0) sh0 = map_pos(p0);
        if (w1) sh1 = map_pos(p1);
        fs_exp = int'(ph == P - 1);
        if (ph == P - 1 && tick_exp < TMAX) tick_exp++;
        ph = (ph == P - 1) ? 0 : ph + 1;
        @(negedge clk);
        pos0_wr = 1'b0;
        pos1_wr = 1'b0;
    endtask

    task automatic align(input int target);
        while (ph != target) step(0, 0, 0, 0);
    endtask

    // measure one full period's high time on both outputs
    task automatic period_width(input string tag, input int e0, input int e1,
                                input bit w0, input bit w1, input int wph,
                                input int p0, input int p1);
        int c0, c1;
        align(0);
        c0 = 0; c1 = 0;
        for (int i = 0; i < P; i++) begin
            c0 += int'(pwm0);
            c1 += int'(pwm1);
            if (i == wph) step(w0, p0, w1, p1);
            else          step(0, 0, 0, 0);
        end
        chk(tag, c0, e0);
        chk(tag, c1, e1);
    endtask

    initial begin
        void'($urandom(20240611));
        sh0 = map_pos(0); sh1 = sh0; ac0 = sh0; ac1 = sh0;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", int'(frame_start), 0);
        chk("R1", int'(tick_count), 0);
        chk("R1", int'(pwm0), 1);
        chk("R1", int'(pwm1), 1);
        chk("R1", map_pos(0), 14);
        rst = 1'b0;
        tg = "R1";
        period_width("R1", 14, 14, 0, 0, 0, 0, 0);

        // R5: mid-period write leaves the running period alone
        tg = "R5";
        period_width("R5", 14, 14, 1, 1, 5, -32768, 32767);
        // R3: extremes of travel
        tg = "R3";
        period_width("R3", 8, 19, 0, 0, 0, 0, 0);
        chk("R3", map_pos(-16384), 11);

        // R8: writing channel 1 only
        tg = "R8";
        period_width("R8", 8, 19, 0, 1, 10, 0, 0);
        period_width("R8", 8, 14, 0, 0, 0, 0, 0);

        // R7: two writes in one period, last one wins
        tg = "R7";
        align(0);
        for (int i = 0; i < P; i++) begin
            if (i == 3)      step(1, 16384, 0, 0);
            else if (i == 7) step(1, -16384, 0, 0);
            else             step(0, 0, 0, 0);
        end
        period_width("R7", 11, 14, 0, 0, 0, 0, 0);

        // R6: write in the final cycle of a period
        tg = "R6";
        align(P - 1);
        step(1, 32767, 0, 0);
        period_width("R6", 11, 14, 0, 0, 0, 0, 0);
        period_width("R6", 19, 14, 0, 0, 0, 0, 0);

        // R9: tick count saturates
        tg = "R9";
        repeat (10 * P) step(0, 0, 0, 0);
        chk("R9", int'(tick_count), TMAX);

        // R4: random writes on both channels
        tg = "R4";
        for (int n = 0; n < 25 * P; n++) begin
            int r, a, b;
            r = int'($urandom % 8);
            a = int'($urandom % 65536) - 32768;
            b = int'($urandom % 65536) - 32768;
            if (($urandom % 16) == 0) a = -32768;
            if (($urandom % 16) == 0) b = 32767;
            step(r == 0 || r == 2, a, r == 1 || r == 2, b);
        end
        chk("R9", int'(tick_count), TMAX);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule